// File: doc/BRIEF.md
# Predicated Instruction Issue Gate

This block sits at the issue point of an in-order pipeline in which every instruction names one predicate register as an extra source operand. Each cycle it looks at the offered instruction, reads that predicate from a small one-bit predicate register file, and decides one of three outcomes. If the predicate is still pending, the instruction is held and stalls the pipe. If the predicate is one, the instruction commits. If the predicate is zero, the instruction is accepted but turns into a no-op.

A committed instruction reaches a single writeback stage one cycle later. There it drives a general-register write. A conditional load instead drives a memory read whose data is written back in the same cycle. Predicate registers get their values in two ways. A predicate-define instruction reserves its destination, and the result arrives later on an external predicate write port. A predicate-invert instruction writes the logical NOT of one predicate register into another, so that both arms of an if/else can be guarded. Each predicate register has a pending bit that is set when a producer issues and cleared when its value is written.

Top module: `pred_issue_gate`

## Requirements
- R1: After reset all predicate values and pending bits are 0, `gpr_we_o` and `mem_re_o` are 0, and with no instruction offered `in_ready_o` is 1.
- R2: An accepted ALU instruction (op code 0) whose predicate register holds 1 raises `gpr_we_o` for exactly the cycle after the accepting edge. In that cycle `gpr_waddr_o` equals `in_dst_i` and `gpr_wdata_o` equals `in_result_i`.
- R3: An accepted instruction whose predicate register holds 0 causes no general-register write, no memory read and no predicate-register change.
- R4: An accepted conditional load (op code 1) with a true predicate drives, in the cycle after the accepting edge, `mem_re_o`=1, `mem_addr_o`=`in_addr_i`, `gpr_we_o`=1, `gpr_waddr_o`=`in_dst_i` and `gpr_wdata_o`=`mem_rdata_i`. With a false predicate, `mem_re_o` stays 0.
- R5: Predicate register 0 always reads 0 and is never pending. Writes to it from the external port or from an invert instruction are ignored. An instruction predicated on it is a no-op.
- R6: A committed predicate-define (op code 2'd3) sets the pending bit of `in_pdst_i` at the accepting edge. An external write (`pw_valid_i`) loads `pw_val_i` into register `pw_idx_i` and clears its pending bit at that edge.
- R7: While the predicate register of the offered instruction is pending, `in_ready_o` is 0. The instruction is accepted at the first edge after the edge that clears the pending bit.
- R8: A committed predicate-invert (op code 2) writes the NOT of register `in_psrc_i` into `in_pdst_i` one edge after acceptance. Its destination is pending between those two edges, so an instruction offered right after it and predicated on that destination stalls exactly one cycle.
- R9: A predicate-invert stalls while `in_psrc_i` is pending. A predicate-invert or predicate-define stalls while `in_pdst_i` is pending, whatever its own predicate value.
- R10: While the offered instruction is stalled, no instruction issues: `gpr_we_o` and `mem_re_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Instruction accepted this cycle (not stalled) |
| in_op_i | input | 2 | 0 ALU, 1 conditional load, 2 predicate invert, 3 predicate define |
| in_pred_i | input | PIDX_W | Guarding predicate register |
| in_dst_i | input | GIDX_W | General destination register |
| in_pdst_i | input | PIDX_W | Predicate destination for invert/define |
| in_psrc_i | input | PIDX_W | Predicate source for invert |
| in_result_i | input | DATA_W | Computed ALU result |
| in_addr_i | input | DATA_W | Load address |
| pw_valid_i | input | 1 | External predicate write |
| pw_idx_i | input | PIDX_W | External predicate write index |
| pw_val_i | input | 1 | External predicate write value |
| gpr_we_o | output | 1 | General register write enable |
| gpr_waddr_o | output | GIDX_W | General register write index |
| gpr_wdata_o | output | DATA_W | General register write data |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | DATA_W | Memory read address |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle |
| pred_val_o | output | PREG_N | Predicate register values |
| pred_pend_o | output | PREG_N | Predicate pending bits |

## Verification
The stall decision in `in_ready_o` is combinational. The bench reads it 1 ns after driving inputs on the falling edge. Writeback and memory-read outputs belong to the cycle after the accepting rising edge, so they are sampled on the falling edge that follows it. Pending bits are set at the accepting edge and cleared at the writeback or external-write edge, and are read on the next falling edge. The one-cycle stall after an invert is counted in falling-edge samples of `in_ready_o`.

// File: rtl/pig_pkg.sv
package pig_pkg;
  typedef enum logic [1:0] {
    OP_ALU  = 2'd0,
    OP_LDC  = 2'd1,
    OP_PNOT = 2'd2,
    OP_PDEF = 2'd3
  } op_e;
endpackage

// File: rtl/pig_pred_file.sv
module pig_pred_file #(
  parameter int PREG_N = 8,
  localparam int PIDX_W = $clog2(PREG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIDX_W-1:0] rd_a_i,
  input  logic [PIDX_W-1:0] rd_b_i,
  input  logic [PIDX_W-1:0] rd_c_i,
  output logic              val_a_o,
  output logic              pend_a_o,
  output logic              val_b_o,
  output logic              pend_b_o,
  output logic              pend_c_o,
  input  logic              rsv_valid_i,
  input  logic [PIDX_W-1:0] rsv_idx_i,
  input  logic              iw_valid_i,
  input  logic [PIDX_W-1:0] iw_idx_i,
  input  logic              iw_val_i,
  input  logic              xw_valid_i,
  input  logic [PIDX_W-1:0] xw_idx_i,
  input  logic              xw_val_i,
  output logic [PREG_N-1:0] val_o,
  output logic [PREG_N-1:0] pend_o
);
  logic [PREG_N-1:0] val_q, pend_q, val_d, pend_d;

  always_comb begin
    val_d  = val_q;
    pend_d = pend_q;
    for (int r = 1; r < PREG_N; r++) begin
      if (xw_valid_i && xw_idx_i == PIDX_W'(r)) begin
        val_d[r]  = xw_val_i;
        pend_d[r] = 1'b0;
      end
      if (iw_valid_i && iw_idx_i == PIDX_W'(r)) begin
        val_d[r]  = iw_val_i;
        pend_d[r] = 1'b0;
      end
      if (rsv_valid_i && rsv_idx_i == PIDX_W'(r)) pend_d[r] = 1'b1;
    end
    val_d[0]  = 1'b0;
    pend_d[0] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      pend_q <= '0;
    end else begin
      val_q  <= val_d;
      pend_q <= pend_d;
    end
  end

  assign val_a_o  = val_q[rd_a_i];
  assign pend_a_o = pend_q[rd_a_i];
  assign val_b_o  = val_q[rd_b_i];
  assign pend_b_o = pend_q[rd_b_i];
  assign pend_c_o = pend_q[rd_c_i];
  assign val_o    = val_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/pig_issue.sv
module pig_issue
  import pig_pkg::*;
(
  input  logic in_valid_i,
  input  op_e  op_i,
  input  logic pred_val_i,
  input  logic pred_pend_i,
  input  logic psrc_pend_i,
  input  logic pdst_pend_i,
  input  logic pdst_nz_i,
  output logic ready_o,
  output logic alu_we_o,
  output logic ldc_o,
  output logic pnot_o,
  output logic rsv_o
);
  logic is_pnot, is_pdef, hazard, commit;

  assign is_pnot = (op_i == OP_PNOT);
  assign is_pdef = (op_i == OP_PDEF);
  // stall decision does not wait on the guard value of hazard sources
  assign hazard  = pred_pend_i
                 | (is_pnot & psrc_pend_i)
                 | ((is_pnot | is_pdef) & pdst_pend_i);
  assign ready_o = ~(in_valid_i & hazard);
  assign commit  = in_valid_i & ~hazard & pred_val_i;

  assign alu_we_o = commit & (op_i == OP_ALU);
  assign ldc_o    = commit & (op_i == OP_LDC);
  assign pnot_o   = commit & is_pnot & pdst_nz_i;
  assign rsv_o    = commit & (is_pnot | is_pdef) & pdst_nz_i;
endmodule

// File: rtl/pig_wb_stage.sv
module pig_wb_stage #(
  parameter int DATA_W = 32,
  parameter int GIDX_W = 5,
  parameter int PIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alu_we_i,
  input  logic              ldc_i,
  input  logic              pnot_i,
  input  logic [GIDX_W-1:0] dst_i,
  input  logic [PIDX_W-1:0] pdst_i,
  input  logic              pnot_val_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              gpr_we_o,
  output logic [GIDX_W-1:0] gpr_waddr_o,
  output logic [DATA_W-1:0] gpr_wdata_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic              iw_valid_o,
  output logic [PIDX_W-1:0] iw_idx_o,
  output logic              iw_val_o
);
  logic              alu_q, ldc_q, pnot_q, pval_q;
  logic [GIDX_W-1:0] dst_q;
  logic [PIDX_W-1:0] pdst_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alu_q  <= 1'b0;
      ldc_q  <= 1'b0;
      pnot_q <= 1'b0;
      pval_q <= 1'b0;
      dst_q  <= '0;
      pdst_q <= '0;
      data_q <= '0;
    end else begin
      alu_q  <= alu_we_i;
      ldc_q  <= ldc_i;
      pnot_q <= pnot_i;
      pval_q <= pnot_val_i;
      dst_q  <= dst_i;
      pdst_q <= pdst_i;
      data_q <= ldc_i ? addr_i : result_i;
    end
  end

  assign gpr_we_o    = alu_q | ldc_q;
  assign gpr_waddr_o = dst_q;
  assign gpr_wdata_o = ldc_q ? mem_rdata_i : data_q;
  assign mem_re_o    = ldc_q;
  assign mem_addr_o  = data_q;
  assign iw_valid_o  = pnot_q;
  assign iw_idx_o    = pdst_q;
  assign iw_val_o    = pval_q;
endmodule

// File: rtl/pred_issue_gate.sv
module pred_issue_gate
  import pig_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GREG_N = 32,
  parameter int PREG_N = 8,
  localparam int GIDX_W = $clog2(GREG_N),
  localparam int PIDX_W = $clog2(PREG_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_op_i,
  input  logic [PIDX_W-1:0] in_pred_i,
  input  logic [GIDX_W-1:0] in_dst_i,
  input  logic [PIDX_W-1:0] in_pdst_i,
  input  logic [PIDX_W-1:0] in_psrc_i,
  input  logic [DATA_W-1:0] in_result_i,
  input  logic [DATA_W-1:0] in_addr_i,
  input  logic              pw_valid_i,
  input  logic [PIDX_W-1:0] pw_idx_i,
  input  logic              pw_val_i,
  output logic              gpr_we_o,
  output logic [GIDX_W-1:0] gpr_waddr_o,
  output logic [DATA_W-1:0] gpr_wdata_o,
  output logic              mem_re_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [PREG_N-1:0] pred_val_o,
  output logic [PREG_N-1:0] pred_pend_o
);
  op_e               op;
  logic              pv, pp, sv, sp, dp;
  logic              alu_we, ldc, pnot, rsv;
  logic              iw_valid, iw_val;
  logic [PIDX_W-1:0] iw_idx;

  assign op = op_e'(in_op_i);

  pig_pred_file #(.PREG_N(PREG_N)) u_pfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_a_i      (in_pred_i),
    .rd_b_i      (in_psrc_i),
    .rd_c_i      (in_pdst_i),
    .val_a_o     (pv),
    .pend_a_o    (pp),
    .val_b_o     (sv),
    .pend_b_o    (sp),
    .pend_c_o    (dp),
    .rsv_valid_i (rsv),
    .rsv_idx_i   (in_pdst_i),
    .iw_valid_i  (iw_valid),
    .iw_idx_i    (iw_idx),
    .iw_val_i    (iw_val),
    .xw_valid_i  (pw_valid_i),
    .xw_idx_i    (pw_idx_i),
    .xw_val_i    (pw_val_i),
    .val_o       (pred_val_o),
    .pend_o      (pred_pend_o)
  );

  pig_issue u_issue (
    .in_valid_i  (in_valid_i),
    .op_i        (op),
    .pred_val_i  (pv),
    .pred_pend_i (pp),
    .psrc_pend_i (sp),
    .pdst_pend_i (dp),
    .pdst_nz_i   (in_pdst_i != '0),
    .ready_o     (in_ready_o),
    .alu_we_o    (alu_we),
    .ldc_o       (ldc),
    .pnot_o      (pnot),
    .rsv_o       (rsv)
  );

  pig_wb_stage #(.DATA_W(DATA_W), .GIDX_W(GIDX_W), .PIDX_W(PIDX_W)) u_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alu_we_i    (alu_we),
    .ldc_i       (ldc),
    .pnot_i      (pnot),
    .dst_i       (in_dst_i),
    .pdst_i      (in_pdst_i),
    .pnot_val_i  (~sv),
    .result_i    (in_result_i),
    .addr_i      (in_addr_i),
    .mem_rdata_i (mem_rdata_i),
    .gpr_we_o    (gpr_we_o),
    .gpr_waddr_o (gpr_waddr_o),
    .gpr_wdata_o (gpr_wdata_o),
    .mem_re_o    (mem_re_o),
    .mem_addr_o  (mem_addr_o),
    .iw_valid_o  (iw_valid),
    .iw_idx_o    (iw_idx),
    .iw_val_o    (iw_val)
  );
endmodule

// File: rtl/pig_checker.sv
module pig_checker
  import pig_pkg::*;
#(
  parameter int PREG_N = 8,
  localparam int PIDX_W = $clog2(PREG_N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [1:0]        in_op_i,
  input logic [PIDX_W-1:0] in_pred_i,
  input logic [PIDX_W-1:0] in_pdst_i,
  input logic [PIDX_W-1:0] in_psrc_i,
  input logic              gpr_we_o,
  input logic              mem_re_o,
  input logic [PREG_N-1:0] pred_val_o,
  input logic [PREG_N-1:0] pred_pend_o
);
  logic fire;
  assign fire = in_valid_i && in_ready_o;

  assert_we_after_fire_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gpr_we_o |-> $past(fire));

  assert_false_pred_noop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !pred_val_o[in_pred_i] |=> !gpr_we_o && !mem_re_o);

  assert_memrd_only_ldc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> $past(in_op_i) == OP_LDC);

  assert_reg0_noop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && in_pred_i == '0 |=> !gpr_we_o && !mem_re_o);

  assert_pdef_reserves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && in_op_i == OP_PDEF && pred_val_o[in_pred_i] && in_pdst_i != '0
    |=> pred_pend_o[$past(in_pdst_i)]);

  assert_stall_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pred_pend_o[in_pred_i] |-> !in_ready_o);

  assert_pnot_src_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_op_i == OP_PNOT && pred_pend_o[in_psrc_i] |-> !in_ready_o);
endmodule

bind pred_issue_gate pig_checker #(.PREG_N(PREG_N)) u_pig_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_op_i     (in_op_i),
  .in_pred_i   (in_pred_i),
  .in_pdst_i   (in_pdst_i),
  .in_psrc_i   (in_psrc_i),
  .gpr_we_o    (gpr_we_o),
  .mem_re_o    (mem_re_o),
  .pred_val_o  (pred_val_o),
  .pred_pend_o (pred_pend_o)
);

// File: tb/pred_issue_gate_tb_top.sv
`timescale 1ns/1ps
module pred_issue_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [1:0]  in_op = 2'd0;
  logic [2:0]  in_pred = '0, in_pdst = '0, in_psrc = '0;
  logic [4:0]  in_dst = '0;
  logic [31:0] in_result = '0, in_addr = '0;
  logic        pw_valid = 1'b0, pw_val = 1'b0;
  logic [2:0]  pw_idx = '0;
  logic        gpr_we, mem_re;
  logic [4:0]  gpr_waddr;
  logic [31:0] gpr_wdata, mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [7:0]  pred_val, pred_pend;
  int          checks = 0, errors = 0;
  int          st;

  localparam logic [1:0] ALU = 2'd0, LDC = 2'd1, PNOT = 2'd2, PDEF = 2'd3;

  always #4 clk = ~clk;

  pred_issue_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op),
    .in_pred_i(in_pred), .in_dst_i(in_dst), .in_pdst_i(in_pdst), .in_psrc_i(in_psrc),
    .in_result_i(in_result), .in_addr_i(in_addr),
    .pw_valid_i(pw_valid), .pw_idx_i(pw_idx), .pw_val_i(pw_val),
    .gpr_we_o(gpr_we), .gpr_waddr_o(gpr_waddr), .gpr_wdata_o(gpr_wdata),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .pred_val_o(pred_val), .pred_pend_o(pred_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [2:0] pred, input logic [2:0] pdst,
                       input logic [2:0] psrc, input logic [4:0] dst,
                       input logic [31:0] res, input logic [31:0] addr);
    in_valid = 1'b1; in_op = op; in_pred = pred; in_pdst = pdst; in_psrc = psrc;
    in_dst = dst; in_result = res; in_addr = addr;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue_one(input logic [1:0] op, input logic [2:0] pred, input logic [2:0] pdst,
                           input logic [2:0] psrc, input logic [4:0] dst,
                           input logic [31:0] res, input logic [31:0] addr, output int stalls);
    drive(op, pred, pdst, psrc, dst, res, addr);
    stalls = 0;
    #1;
    while (!in_ready) begin
      @(posedge clk); @(negedge clk); #1;
      stalls++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [2:0] idx, input logic v);
    pw_valid = 1'b1; pw_idx = idx; pw_val = v;
    @(posedge clk); #1;
    pw_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pred_val", 32'(pred_val), 32'h0);
    chk("R1 pred_pend", 32'(pred_pend), 32'h0);
    chk("R1 gpr_we", 32'(gpr_we), 32'h0);
    chk("R1 mem_re", 32'(mem_re), 32'h0);
    chk("R1 ready", 32'(in_ready), 32'h1);
  endtask

  task automatic t_alu;
    pwrite(3'd1, 1'b1);
    chk("R6 ext write val", 32'(pred_val[1]), 32'h1);
    issue_one(ALU, 3'd1, 3'd0, 3'd0, 5'd5, 32'hA5A5_0001, 32'h0, st);
    chk("R2 we", 32'(gpr_we), 32'h1);
    chk("R2 waddr", 32'(gpr_waddr), 32'd5);
    chk("R2 wdata", gpr_wdata, 32'hA5A5_0001);
    @(posedge clk); @(negedge clk);
    chk("R2 single cycle", 32'(gpr_we), 32'h0);
  endtask

  task automatic t_kill;
    issue_one(ALU, 3'd2, 3'd0, 3'd0, 5'd6, 32'h1234, 32'h0, st);
    chk("R3 alu killed we", 32'(gpr_we), 32'h0);
    issue_one(LDC, 3'd2, 3'd0, 3'd0, 5'd6, 32'h0, 32'h40, st);
    chk("R4 ldc killed mem_re", 32'(mem_re), 32'h0);
    chk("R3 ldc killed we", 32'(gpr_we), 32'h0);
    issue_one(PNOT, 3'd2, 3'd3, 3'd2, 5'd0, 32'h0, 32'h0, st);
    chk("R3 pnot killed pend", 32'(pred_pend), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R3 pnot killed val", 32'(pred_val), 32'h02);
  endtask

  task automatic t_ldc;
    mem_rdata = 32'hDEAD_BEEF;
    issue_one(LDC, 3'd1, 3'd0, 3'd0, 5'd7, 32'h0, 32'h100, st);
    chk("R4 mem_re", 32'(mem_re), 32'h1);
    chk("R4 mem_addr", mem_addr, 32'h100);
    chk("R4 we", 32'(gpr_we), 32'h1);
    chk("R4 waddr", 32'(gpr_waddr), 32'd7);
    chk("R4 wdata", gpr_wdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_reg0;
    pwrite(3'd0, 1'b1);
    chk("R5 ext write ignored", 32'(pred_val[0]), 32'h0);
    issue_one(ALU, 3'd0, 3'd0, 3'd0, 5'd8, 32'h77, 32'h0, st);
    chk("R5 no stall", 32'(st), 32'd0);
    chk("R5 noop we", 32'(gpr_we), 32'h0);
    issue_one(PNOT, 3'd1, 3'd0, 3'd0, 5'd0, 32'h0, 32'h0, st);
    chk("R5 never pending", 32'(pred_pend[0]), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R5 invert ignored", 32'(pred_val[0]), 32'h0);
  endtask

  task automatic t_pdef;
    issue_one(PDEF, 3'd1, 3'd3, 3'd0, 5'd0, 32'h0, 32'h0, st);
    chk("R6 reserve pending", 32'(pred_pend[3]), 32'h1);
    drive(ALU, 3'd3, 3'd0, 3'd0, 5'd9, 32'h33, 32'h0);
    #1;
    chk("R7 stall on pending", 32'(in_ready), 32'h0);
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R7 still stalled", 32'(in_ready), 32'h0);
      chk("R10 no issue we", 32'(gpr_we), 32'h0);
      chk("R10 no issue mem", 32'(mem_re), 32'h0);
    end
    pw_valid = 1'b1; pw_idx = 3'd3; pw_val = 1'b1;
    @(posedge clk); #1;
    pw_valid = 1'b0;
    chk("R6 ext clears pend", 32'(pred_pend[3]), 32'h0);
    chk("R6 ext sets val", 32'(pred_val[3]), 32'h1);
    chk("R7 ready after clear", 32'(in_ready), 32'h1);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 issued we", 32'(gpr_we), 32'h1);
    chk("R7 issued wdata", gpr_wdata, 32'h33);
  endtask

  task automatic t_pnot;
    issue_one(PNOT, 3'd1, 3'd4, 3'd3, 5'd0, 32'h0, 32'h0, st);
    chk("R8 dst pending", 32'(pred_pend[4]), 32'h1);
    issue_one(ALU, 3'd4, 3'd0, 3'd0, 5'd10, 32'h44, 32'h0, st);
    chk("R8 one stall", 32'(st), 32'd1);
    chk("R8 not of one", 32'(pred_val[4]), 32'h0);
    chk("R8 guarded by zero", 32'(gpr_we), 32'h0);
    issue_one(PNOT, 3'd1, 3'd5, 3'd4, 5'd0, 32'h0, 32'h0, st);
    issue_one(ALU, 3'd5, 3'd0, 3'd0, 5'd11, 32'h55, 32'h0, st);
    chk("R8 one stall b", 32'(st), 32'd1);
    chk("R8 not of zero", 32'(pred_val[5]), 32'h1);
    chk("R8 guarded by one", 32'(gpr_we), 32'h1);
  endtask

  task automatic t_hazard;
    issue_one(PDEF, 3'd1, 3'd6, 3'd0, 5'd0, 32'h0, 32'h0, st);
    drive(PNOT, 3'd1, 3'd2, 3'd6, 5'd0, 32'h0, 32'h0);
    #1;
    chk("R9 src pending stall", 32'(in_ready), 32'h0);
    drive(PNOT, 3'd0, 3'd6, 3'd1, 5'd0, 32'h0, 32'h0);
    #1;
    chk("R9 dst pending stall", 32'(in_ready), 32'h0);
    drive(PDEF, 3'd1, 3'd6, 3'd0, 5'd0, 32'h0, 32'h0);
    #1;
    chk("R9 pdef dst pending stall", 32'(in_ready), 32'h0);
    in_valid = 1'b0;
    @(negedge clk);
    pwrite(3'd6, 1'b0);
    issue_one(PNOT, 3'd1, 3'd2, 3'd6, 5'd0, 32'h0, 32'h0, st);
    chk("R9 issues once clear", 32'(st), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 invert result", 32'(pred_val[2]), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_kill();
    t_ldc();
    t_reg0();
    t_pdef();
    t_pnot();
    t_hazard();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule